// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter for a microcontroller subsystem. It runs from the moment reset is released, advances on each pulse of a slow time-base tick, and signals a fault when software does not service it in time. Software sees two byte-wide registers on a simple register port. A control register chooses the operating mode and the timeout length. A service register restarts the count when it receives the correct key byte.

Three things force the overflow at once, without waiting for the count to run out: a wrong key, a partial (bit-level) write to the service register, or a second write to the control register. The control register accepts only one write after each reset. Any later write does not change it.

Each overflow is a one-cycle pulse on `ovf_o`, which a reset-cause block can record. In the same cycle the pulse also appears on either the system reset request or the non-maskable interrupt request, depending on the active mode. In the stopped mode the block neither counts nor faults.

Top module: `key_wdt`

## Requirements
- R1: After reset the control register reads 0x67. The watchdog is then running in reset mode with a 2^16-tick timeout, and all three pulse outputs are low.
- R2: Control register fields are as follows. Bit 7 always reads 0. Bits 6:5 select the mode: 00 stopped, 01 interrupt, 1x reset. Bits 2:0 give a code c that sets the timeout to 2^(9+c) ticks. Bits 4:3 are stored and read back but do not change the timeout.
- R3: An overflow happens on the 2^(9+c)-th tick after the last clear. It appears as a one-cycle pulse in the cycle after that tick's clock edge. The pulse is on `ovf_o`, together with `rst_req_o` in reset mode or `nmi_o` in interrupt mode. The count then restarts from zero.
- R4: A full-byte write of 0xAC to address 1 clears the count, and no overflow results. If the key arrives in the same cycle as the final tick, the key wins.
- R5: Address 1 always reads 0x9A.
- R6: Only the first control-register write (address 0) after reset is accepted. That write also restarts the count. Later writes leave the stored value unchanged.
- R7: While running, any of the following gives an overflow pulse in the next cycle: a control-register write after the first, a full-byte write to address 1 of any value other than 0xAC, or a bit write (`full_i`=0) to address 1.
- R8: In the stopped mode the count does not advance, and none of the R7 misuses gives an overflow.
- R9: `rst_req_o` and `nmi_o` are never high together, and each is high only together with `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one clock wide per count step |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = control register, 1 = service register |
| full_i | input | 1 | 1 = full-byte write, 0 = bit-level write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| ovf_o | output | 1 | Overflow event pulse |
| rst_req_o | output | 1 | System reset request pulse |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
The hardest case to reach from the ports is the race between the key and the final tick. The count has to sit exactly one tick short of its limit, and then the key write and the last tick must arrive in the same clock cycle. The bench gets there by holding `tick_i` high for an exact number of cycles, then raising the tick and the key write together. A second case is a key written just after an interrupt-mode overflow, which shows that the restarted count still needs the full timeout. The stopped-mode case uses a short timeout code and runs well past it to show that no pulse appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_VAL    = 8'hAC;
  localparam logic [7:0] SVC_RD_VAL = 8'h9A;
  localparam logic [6:0] CTRL_INIT  = 7'h67;

  typedef enum logic [1:0] {WM_STOP, WM_NMI, WM_RST} wdt_mode_e;

  function automatic wdt_mode_e decode_mode(input logic [1:0] f);
    if (f[1]) return WM_RST;
    if (f[0]) return WM_NMI;
    return WM_STOP;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic             full_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output wdt_mode_e        mode_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clr_o,
  output logic             force_o
);
  logic [6:0] ctrl_q;
  logic       locked_q;
  logic       ctrl_wr, svc_wr, key_ok, running;

  assign ctrl_wr = req_i & we_i & ~addr_i;
  assign svc_wr  = req_i & we_i & addr_i;
  assign key_ok  = full_i & (wdata_i == KEY_VAL);
  assign mode_o  = decode_mode(ctrl_q[6:5]);
  assign running = (mode_o != WM_STOP);
  assign sel_o   = ctrl_q[SEL_W-1:0];

  // accepted control write restarts the count
  assign clr_o   = (svc_wr & key_ok) | (ctrl_wr & ~locked_q);
  assign force_o = running & ((svc_wr & ~key_ok) | (ctrl_wr & locked_q));

  assign rdata_o = addr_i ? SVC_RD_VAL : {1'b0, ctrl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_INIT;
      locked_q <= 1'b0;
    end else if (ctrl_wr && !locked_q) begin
      ctrl_q   <= wdata_i[6:0];
      locked_q <= 1'b1;
    end
  end

  // R6: once locked, the control value never moves
  a_r6_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_EXP = 9,
  parameter int SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             force_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fire_o
);
  localparam int N_LEN = 2 ** SEL_W;
  localparam int CNT_W = BASE_EXP + N_LEN - 1;

  logic [CNT_W-1:0] last_w [N_LEN];
  logic [CNT_W-1:0] cnt_q;
  logic             at_end, tick_fire;

  for (genvar i = 0; i < N_LEN; i++) begin : g_len
    assign last_w[i] = {CNT_W{1'b1}} >> (N_LEN - 1 - i);
  end

  assign at_end    = (cnt_q == last_w[sel_i]);
  assign tick_fire = run_i & tick_i & at_end & ~clr_i;
  assign fire_o    = tick_fire | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i || clr_i || fire_o) cnt_q <= '0;
    else if (tick_i)                   cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/key_wdt.sv
module key_wdt
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 9,
  parameter int SEL_W    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic       full_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ovf_o,
  output logic       rst_req_o,
  output logic       nmi_o
);
  wdt_mode_e        mode;
  logic [SEL_W-1:0] sel;
  logic             clr, force_ovf, fire;
  logic             ovf_q, rst_q, nmi_q;

  wdt_regs #(.SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .full_i, .wdata_i,
    .rdata_o, .mode_o(mode), .sel_o(sel), .clr_o(clr), .force_o(force_ovf)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .run_i(mode != WM_STOP), .clr_i(clr),
    .force_i(force_ovf), .sel_i(sel), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      ovf_q <= fire;
      rst_q <= fire & (mode == WM_RST);
      nmi_q <= fire & (mode == WM_NMI);
    end
  end

  assign ovf_o     = ovf_q;
  assign rst_req_o = rst_q;
  assign nmi_o     = nmi_q;

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_req_o, nmi_o}));
  a_r9_with_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || nmi_o) |-> ovf_o);
  a_r7_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ovf |=> ovf_o);
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WM_STOP) |=> !ovf_o);
endmodule

// File: tb/key_wdt_tb.sv
module key_wdt_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0, addr_i = 1'b0, full_i = 1'b1;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       ovf_o, rst_req_o, nmi_o;

  int n_chk = 0, n_err = 0;

  key_wdt u_dut (.*);

  always #2 clk_i = ~clk_i;

  // {we, addr, full, data[7:0], exp_rd[7:0], exp_rst, exp_nmi}
  localparam logic [20:0] TBL [11] = '{
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h67, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h9A, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'hAC, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'hB3, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'hAC, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'h55, 8'h00, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'hAC, 8'h00, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b1, 8'h53, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h9A, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one bus cycle; outputs sampled at the negedge after the capturing edge
  task automatic bus(input bit we, input bit addr, input bit full, input logic [7:0] d,
                     output logic [7:0] rd, output bit o_rst, output bit o_nmi, output bit o_ovf);
    req_i = 1'b1; we_i = we; addr_i = addr; full_i = full; wdata_i = d;
    #1 rd = rdata_o;
    @(negedge clk_i);
    o_rst = rst_req_o; o_nmi = nmi_o; o_ovf = ovf_o;
    req_i = 1'b0; we_i = 1'b0; full_i = 1'b1;
  endtask

  task automatic ticks(input int n, output int c_rst, output int c_nmi, output bit last_hit);
    c_rst = 0; c_nmi = 0; last_hit = 1'b0;
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (rst_req_o) c_rst++;
      if (nmi_o) c_nmi++;
      if (i == n - 1) last_hit = ovf_o;
    end
    tick_i = 1'b0;
  endtask

  task automatic wr(input bit addr, input bit full, input logic [7:0] d, output bit o_ovf);
    logic [7:0] rd; bit r, m;
    bus(1'b1, addr, full, d, rd, r, m, o_ovf);
  endtask

  initial begin
    #(190000 * 4);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd; bit r, m, o, hit; int cr, cn;

    // reset state (R1)
    #1;
    check(!ovf_o && !rst_req_o && !nmi_o, "R1 outputs in reset", {ovf_o, rst_req_o, nmi_o}, 0);
    do_reset();
    addr_i = 1'b0; #1;
    check(rdata_o == 8'h67, "R1 ctrl reset value", rdata_o, 8'h67);

    // table walk
    for (int k = 0; k < 11; k++) begin
      logic [20:0] e;
      e = TBL[k];
      bus(e[20], e[19], e[18], e[17:10], rd, r, m, o);
      if (!e[20]) begin
        check(rd == e[9:2], e[19] ? "R5 svc readback" : "R6 ctrl readback", rd, e[9:2]);
        check(!o, "R9 no pulse on read", o, 0);
      end else begin
        check(r == e[1] && m == e[0] && o == (e[1] | e[0]), "R7 write outcome",
              {o, r, m}, {e[1] | e[0], e[1], e[0]});
      end
    end

    // default reset-mode timeout 2^16 (R1, R3)
    do_reset();
    ticks(65535, cr, cn, hit);
    check(cr == 0 && cn == 0, "R1 no early overflow", cr + cn, 0);
    ticks(1, cr, cn, hit);
    check(hit && cr == 1 && cn == 0, "R3 reset pulse at 2^16", {hit, cr[3:0], cn[3:0]}, 9'h110);
    @(negedge clk_i);
    check(!ovf_o && !rst_req_o, "R3 one-cycle pulse", {ovf_o, rst_req_o}, 0);

    // reset mode, code 11011: bits 4:3 ignored -> 4096 ticks (R2, R4)
    do_reset();
    wr(1'b0, 1'b1, 8'h5B, o);
    addr_i = 1'b0; #1;
    check(rdata_o == 8'h5B, "R2 ctrl stored", rdata_o, 8'h5B);
    ticks(4095, cr, cn, hit);
    check(cr == 0 && cn == 0, "R2 no overflow before 4096", cr + cn, 0);
    wr(1'b1, 1'b1, 8'hAC, o);
    check(!o, "R4 key no pulse", o, 0);
    ticks(4095, cr, cn, hit);
    check(cr == 0 && cn == 0, "R4 key restarted count", cr + cn, 0);
    ticks(1, cr, cn, hit);
    check(hit && cr == 1 && cn == 0, "R3 reset pulse after key", {hit, cr[3:0], cn[3:0]}, 9'h110);

    // interval code 001 -> 1024 ticks (R2)
    do_reset();
    wr(1'b0, 1'b1, 8'h61, o);
    ticks(1023, cr, cn, hit);
    check(cr == 0, "R2 code 001 early", cr, 0);
    ticks(1, cr, cn, hit);
    check(hit && cr == 1, "R2 code 001 at 1024", {hit, cr[3:0]}, 5'h11);

    // interrupt mode, key on the final tick (R4), restart (R3), key after overflow
    do_reset();
    wr(1'b0, 1'b1, 8'h33, o);
    ticks(4095, cr, cn, hit);
    tick_i = 1'b1;
    wr(1'b1, 1'b1, 8'hAC, o);
    tick_i = 1'b0;
    check(!o && !nmi_o, "R4 key wins over final tick", {o, nmi_o}, 0);
    ticks(4095, cr, cn, hit);
    check(cn == 0, "R4 count cleared by race key", cn, 0);
    ticks(1, cr, cn, hit);
    check(hit && cn == 1 && cr == 0, "R3 nmi pulse", {hit, cn[3:0], cr[3:0]}, 9'h110);
    ticks(4095, cr, cn, hit);
    check(cn == 0, "R3 count restarted after overflow", cn, 0);
    ticks(1, cr, cn, hit);
    check(hit && cn == 1, "R3 second nmi", {hit, cn[3:0]}, 5'h11);
    wr(1'b1, 1'b1, 8'hAC, o);
    check(!o && !nmi_o, "R4 key after overflow no effect", {o, nmi_o}, 0);
    ticks(4095, cr, cn, hit);
    check(cn == 0, "R4 key after overflow quiet", cn, 0);
    ticks(1, cr, cn, hit);
    check(hit && cn == 1, "R3 nmi full interval", {hit, cn[3:0]}, 5'h11);

    // stopped mode (R8)
    do_reset();
    wr(1'b0, 1'b1, 8'h00, o);
    ticks(600, cr, cn, hit);
    check(cr == 0 && cn == 0, "R8 stopped no count", cr + cn, 0);
    wr(1'b1, 1'b1, 8'h12, o);
    check(!o, "R8 wrong key ignored", o, 0);
    wr(1'b1, 1'b0, 8'hAC, o);
    check(!o, "R8 bit write ignored", o, 0);
    wr(1'b0, 1'b1, 8'h53, o);
    check(!o, "R8 second ctrl write ignored", o, 0);
    addr_i = 1'b0; #1;
    check(rdata_o == 8'h00, "R6 ctrl unchanged when stopped", rdata_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule